// File: doc/BRIEF.md
# Load-Store Data Alignment Formatter

This block sits between a word-wide data memory port and a processor's register file. It moves data in both directions. For loads, it takes the 32-bit word that memory returns for the word-aligned address and turns it into the value written to a register. For stores, it takes a register value and produces the 32-bit write data plus one write enable per byte lane. The inputs that steer it are:

- the two low address bits,
- the access size (byte, halfword or word),
- a sign-extension flag,
- an endianness select.

The block is purely combinational, and the load and store paths work side by side on the shared controls. Unaligned word loads are not trapped. Instead, the word is rotated so that the addressed byte lands in the least significant lane (little-endian) or the most significant lane (big-endian).

Top module: `lsfmt_top`

## Requirements
- R1: Size code 2'b00 is a byte access. A byte load places the addressed byte in bits 7:0 and clears bits 31:8 when `sign_ext` is 0.
- R2: A byte load with `sign_ext` = 1 copies bit 7 of the loaded byte into bits 31:8.
- R3: Size code 2'b01 is a halfword access, and `addr_lo[0]` is ignored for it. A halfword load with `sign_ext` = 0 returns the halfword in bits 15:0 with bits 31:16 cleared. The halfword is `ld_word[15:0]` when `addr_lo[1]` equals `big_endian`, and `ld_word[31:16]` otherwise.
- R4: A halfword load with `sign_ext` = 1 copies bit 15 into bits 31:16.
- R5: Size code 2'b10 is a word access. In little-endian mode (`big_endian` = 0), a word load returns `ld_word` rotated right by 8 × `addr_lo` bits.
- R6: In big-endian mode, a word load returns `ld_word` rotated left by 8 × `addr_lo` bits. An aligned word passes through unchanged.
- R7: The byte at address offset a sits in lane a (bits 8a+7:8a) in little-endian mode and in lane 3−a in big-endian mode.
- R8: A byte store replicates `st_reg[7:0]` into all four lanes and asserts exactly one enable bit, the one for the lane given by R7.
- R9: A halfword store replicates `st_reg[15:0]` into both halves, with `st_reg[7:0]` in the even lanes. It enables lanes 1:0 (`st_byte_en` = 4'b0011) when `addr_lo[1]` equals `big_endian`, and lanes 3:2 (4'b1100) otherwise. `addr_lo[0]` has no effect.
- R10: A word store outputs `st_reg` unchanged with all four enables set, whatever `addr_lo` is. Size code 2'b11 behaves as a word access. `sign_ext` has no effect on word loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ld_word | input | 32 | Word read from the word-aligned memory address |
| addr_lo | input | 2 | Low two bits of the byte address |
| acc_size | input | 2 | Access size: 00 byte, 01 halfword, 10/11 word |
| sign_ext | input | 1 | Sign-extend byte and halfword loads |
| big_endian | input | 1 | 1 selects big-endian lane numbering |
| st_reg | input | 32 | Register value to be stored |
| ld_result | output | 32 | Formatted load value for the register file |
| st_data | output | 32 | Lane-placed write data for memory |
| st_byte_en | output | 4 | Per-lane write enables, bit i for bits 8i+7:8i |

## Verification
The bench drives every offset for each size in both endian modes. A design that mirrors lanes the wrong way returns the byte at the opposite end of the word, and the distinct byte values in the test words expose that at once.

Word offsets 1 to 3 are checked against hand-computed rotations in both modes. This catches a rotate in the wrong direction, and a design that forces unaligned words back to alignment.

Sign extension is checked with bytes and halfwords whose top bit is both set and clear. A design that extends from the wrong bit, or extends unsigned loads, fails these checks.

Several cases are also targeted directly:
- odd halfword offsets, where a design that uses `addr_lo[0]` picks a straddling pair;
- the reserved size code;
- `sign_ext` set on word accesses;
- a big-endian store followed by a byte load from the stored data.

// File: rtl/lsfmt_pkg.sv
// Package: shared widths and access-size encoding for the load-store formatter.
// Assumes a memory word of LANES byte lanes, each BYTE_W bits wide.
package lsfmt_pkg;
    localparam int BYTE_W  = 8;
    localparam int LANES   = 4;
    localparam int WORD_W  = BYTE_W * LANES;
    localparam int OFS_W   = $clog2(LANES);
    localparam int HALF_W  = 2 * BYTE_W;

    // Access size; the fourth code is treated as a full word.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_t;
endpackage

// File: rtl/lsfmt_lane_sel.sv
// Module: lsfmt_lane_sel
// Maps an address offset and the endianness select to physical lane choices:
// the lane of an addressed byte, which half holds an addressed halfword, and
// the right-rotate amount (in bytes) that brings the addressed byte to the
// register's low lane (little-endian) or high lane (big-endian).
// Assumes a power-of-two lane count.
module lsfmt_lane_sel
    import lsfmt_pkg::*;
(
    input  logic [OFS_W-1:0] addr_lo,
    input  logic             big_endian,
    output logic [OFS_W-1:0] byte_lane,
    output logic             half_upper,
    output logic [OFS_W-1:0] rot_amt
);
    // Byte lane: offset directly, or mirrored for big-endian.
    always_comb begin
        byte_lane = big_endian ? ~addr_lo : addr_lo;
    end

    // Halfword half: the offset's upper bit, flipped by big-endian order.
    always_comb begin
        half_upper = addr_lo[OFS_W-1] ^ big_endian;
    end

    // Rotate amount: right by offset, or right by negated offset (left rotate).
    always_comb begin
        rot_amt = big_endian ? (OFS_W'(0) - addr_lo) : addr_lo;
    end
endmodule

// File: rtl/lsfmt_load.sv
// Module: lsfmt_load
// Turns a word read from memory into a register value: byte and halfword
// extraction with zero or sign extension, and rotated unaligned words.
// Assumes lane choices come from lsfmt_lane_sel.
module lsfmt_load
    import lsfmt_pkg::*;
(
    input  logic [WORD_W-1:0] ld_word,
    input  acc_size_t         acc_size,
    input  logic              sign_ext,
    input  logic              big_endian,
    input  logic [OFS_W-1:0]  byte_lane,
    input  logic              half_upper,
    input  logic [OFS_W-1:0]  rot_amt,
    output logic [WORD_W-1:0] ld_result
);
    logic [2*WORD_W-1:0] doubled;
    logic [WORD_W-1:0]   rotated;
    logic [BYTE_W-1:0]   pick_byte;
    logic [HALF_W-1:0]   pick_half;
    logic [BYTE_W-1:0]   lane_bytes [LANES];

    // Split the memory word into lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = ld_word[g*BYTE_W +: BYTE_W];
    end

    // Rotate right by whole bytes using a doubled word.
    always_comb begin
        doubled = {ld_word, ld_word};
        rotated = doubled[rot_amt*BYTE_W +: WORD_W];
    end

    // Select the addressed byte and halfword.
    always_comb begin
        pick_byte = lane_bytes[byte_lane];
        pick_half = half_upper ? ld_word[WORD_W-1 -: HALF_W] : ld_word[HALF_W-1:0];
    end

    // Extend narrow values or pass the rotated word.
    always_comb begin
        unique case (acc_size)
            SZ_BYTE: ld_result = {{(WORD_W-BYTE_W){sign_ext & pick_byte[BYTE_W-1]}}, pick_byte};
            SZ_HALF: ld_result = {{(WORD_W-HALF_W){sign_ext & pick_half[HALF_W-1]}}, pick_half};
            default: ld_result = rotated;
        endcase
    end

    // Cross-check the byte path against the independent rotate path.
    always_comb begin
        if (acc_size == SZ_BYTE) begin
            // R7
            byte_via_rotate_chk: assert (ld_result[BYTE_W-1:0] ==
                (big_endian ? rotated[WORD_W-1 -: BYTE_W] : rotated[BYTE_W-1:0]))
                else $error("byte lane disagrees with rotate path");
        end
    end

    // Sign-extended narrow loads must have uniform upper bits.
    always_comb begin
        if (acc_size == SZ_BYTE && sign_ext) begin
            // R2
            byte_sext_chk: assert (ld_result[WORD_W-1:BYTE_W] == '0 ||
                                   ld_result[WORD_W-1:BYTE_W-1] == '1)
                else $error("byte sign extension broken");
        end
        if (acc_size == SZ_HALF && !sign_ext) begin
            // R3
            half_zext_chk: assert (ld_result[WORD_W-1:HALF_W] == '0)
                else $error("halfword zero fill broken");
        end
    end
endmodule

// File: rtl/lsfmt_store.sv
// Module: lsfmt_store
// Places a register value on the memory write lanes and forms the byte
// enables. Narrow data is replicated on every lane; enables pick the lanes.
// Assumes lane choices come from lsfmt_lane_sel.
module lsfmt_store
    import lsfmt_pkg::*;
(
    input  logic [WORD_W-1:0] st_reg,
    input  acc_size_t         acc_size,
    input  logic [OFS_W-1:0]  byte_lane,
    input  logic              half_upper,
    output logic [WORD_W-1:0] st_data,
    output logic [LANES-1:0]  st_byte_en
);
    // Per-lane data: replicated byte, replicated halfword, or straight word.
    for (genvar g = 0; g < LANES; g++) begin : g_wlane
        always_comb begin
            unique case (acc_size)
                SZ_BYTE: st_data[g*BYTE_W +: BYTE_W] = st_reg[BYTE_W-1:0];
                SZ_HALF: st_data[g*BYTE_W +: BYTE_W] = st_reg[(g%2)*BYTE_W +: BYTE_W];
                default: st_data[g*BYTE_W +: BYTE_W] = st_reg[g*BYTE_W +: BYTE_W];
            endcase
        end
    end

    // Enables: one lane, one half, or every lane.
    always_comb begin
        unique case (acc_size)
            SZ_BYTE: st_byte_en = LANES'(1) << byte_lane;
            SZ_HALF: st_byte_en = half_upper ? {2'b11, {(LANES-2){1'b0}}}
                                             : {{(LANES-2){1'b0}}, 2'b11};
            default: st_byte_en = '1;
        endcase
    end

    // Enable counts per size, and enabled byte lanes carry the register byte.
    always_comb begin
        if (acc_size == SZ_BYTE) begin
            // R8
            byte_en_onehot_chk: assert ($countones(st_byte_en) == 1)
                else $error("byte store enables not one-hot");
            // R8
            byte_lane_data_chk: assert (st_data[byte_lane*BYTE_W +: BYTE_W] == st_reg[BYTE_W-1:0])
                else $error("byte store lane data wrong");
        end
        if (acc_size == SZ_HALF) begin
            // R9
            half_en_count_chk: assert ($countones(st_byte_en) == 2)
                else $error("halfword store enable count wrong");
        end
        if (acc_size == SZ_WORD || acc_size == SZ_RSVD) begin
            // R10
            word_en_all_chk: assert (st_byte_en == '1 && st_data == st_reg)
                else $error("word store not pass-through");
        end
    end
endmodule

// File: rtl/lsfmt_top.sv
// Module: lsfmt_top
// Load-store data alignment formatter. Combinational; the load and store
// paths share the size, offset and endianness controls.
// Assumes ld_word was read from the word-aligned address.
module lsfmt_top
    import lsfmt_pkg::*;
(
    input  logic [31:0] ld_word,
    input  logic [1:0]  addr_lo,
    input  logic [1:0]  acc_size,
    input  logic        sign_ext,
    input  logic        big_endian,
    input  logic [31:0] st_reg,
    output logic [31:0] ld_result,
    output logic [31:0] st_data,
    output logic [3:0]  st_byte_en
);
    logic [OFS_W-1:0] byte_lane;
    logic             half_upper;
    logic [OFS_W-1:0] rot_amt;
    acc_size_t        size_e;

    // Cast the raw size code to the shared enum.
    always_comb begin
        size_e = acc_size_t'(acc_size);
    end

    lsfmt_lane_sel u_lane (
        .addr_lo    (addr_lo),
        .big_endian (big_endian),
        .byte_lane  (byte_lane),
        .half_upper (half_upper),
        .rot_amt    (rot_amt)
    );

    lsfmt_load u_load (
        .ld_word    (ld_word),
        .acc_size   (size_e),
        .sign_ext   (sign_ext),
        .big_endian (big_endian),
        .byte_lane  (byte_lane),
        .half_upper (half_upper),
        .rot_amt    (rot_amt),
        .ld_result  (ld_result)
    );

    lsfmt_store u_store (
        .st_reg     (st_reg),
        .acc_size   (size_e),
        .byte_lane  (byte_lane),
        .half_upper (half_upper),
        .st_data    (st_data),
        .st_byte_en (st_byte_en)
    );
endmodule

// File: tb/lsfmt_top_test.sv
// Bench for lsfmt_top: table of vectors walked by one loop, then directed cases.
module lsfmt_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ld_word = '0;
    logic [1:0]  addr_lo = '0;
    logic [1:0]  acc_size = '0;
    logic        sign_ext = 1'b0;
    logic        big_endian = 1'b0;
    logic [31:0] st_reg = '0;
    logic [31:0] ld_result;
    logic [31:0] st_data;
    logic [3:0]  st_byte_en;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lsfmt_top uut (
        .ld_word    (ld_word),
        .addr_lo    (addr_lo),
        .acc_size   (acc_size),
        .sign_ext   (sign_ext),
        .big_endian (big_endian),
        .st_reg     (st_reg),
        .ld_result  (ld_result),
        .st_data    (st_data),
        .st_byte_en (st_byte_en)
    );

    // Vector: store, size, offset, signed, big-endian, input, expected data, expected enables, req.
    localparam int NV = 47;
    localparam logic [78:0] VEC [NV] = '{
        {1'b0,2'd0,2'd0,1'b0,1'b0,32'h11223344,32'h00000044,4'h0,4'd1}, // R1 R7
        {1'b0,2'd0,2'd1,1'b0,1'b0,32'h11223344,32'h00000033,4'h0,4'd1}, // R1
        {1'b0,2'd0,2'd2,1'b0,1'b0,32'h11223344,32'h00000022,4'h0,4'd1}, // R1
        {1'b0,2'd0,2'd3,1'b0,1'b0,32'h11223344,32'h00000011,4'h0,4'd1}, // R1
        {1'b0,2'd0,2'd0,1'b0,1'b1,32'h11223344,32'h00000011,4'h0,4'd7}, // R7
        {1'b0,2'd0,2'd1,1'b0,1'b1,32'h11223344,32'h00000022,4'h0,4'd7}, // R7
        {1'b0,2'd0,2'd3,1'b0,1'b1,32'h11223344,32'h00000044,4'h0,4'd7}, // R7
        {1'b0,2'd0,2'd3,1'b0,1'b0,32'h80FF7F01,32'h00000080,4'h0,4'd1}, // R1
        {1'b0,2'd0,2'd3,1'b1,1'b0,32'h80FF7F01,32'hFFFFFF80,4'h0,4'd2}, // R2
        {1'b0,2'd0,2'd2,1'b1,1'b0,32'h80FF7F01,32'hFFFFFFFF,4'h0,4'd2}, // R2
        {1'b0,2'd0,2'd1,1'b1,1'b0,32'h80FF7F01,32'h0000007F,4'h0,4'd2}, // R2
        {1'b0,2'd0,2'd0,1'b1,1'b1,32'h80FF7F01,32'hFFFFFF80,4'h0,4'd2}, // R2
        {1'b0,2'd1,2'd0,1'b0,1'b0,32'h8001F234,32'h0000F234,4'h0,4'd3}, // R3
        {1'b0,2'd1,2'd1,1'b0,1'b0,32'h8001F234,32'h0000F234,4'h0,4'd3}, // R3
        {1'b0,2'd1,2'd2,1'b0,1'b0,32'h8001F234,32'h00008001,4'h0,4'd3}, // R3
        {1'b0,2'd1,2'd3,1'b0,1'b0,32'h8001F234,32'h00008001,4'h0,4'd3}, // R3
        {1'b0,2'd1,2'd0,1'b0,1'b1,32'h8001F234,32'h00008001,4'h0,4'd3}, // R3
        {1'b0,2'd1,2'd2,1'b0,1'b1,32'h8001F234,32'h0000F234,4'h0,4'd3}, // R3
        {1'b0,2'd1,2'd0,1'b1,1'b0,32'h8001F234,32'hFFFFF234,4'h0,4'd4}, // R4
        {1'b0,2'd1,2'd1,1'b1,1'b0,32'h8001F234,32'hFFFFF234,4'h0,4'd4}, // R4
        {1'b0,2'd1,2'd2,1'b1,1'b0,32'h8001F234,32'hFFFF8001,4'h0,4'd4}, // R4
        {1'b0,2'd1,2'd3,1'b1,1'b1,32'h8001F234,32'hFFFFF234,4'h0,4'd4}, // R4
        {1'b0,2'd1,2'd2,1'b1,1'b0,32'h7FFF1234,32'h00007FFF,4'h0,4'd4}, // R4
        {1'b0,2'd2,2'd0,1'b0,1'b0,32'h0982A22E,32'h0982A22E,4'h0,4'd5}, // R5
        {1'b0,2'd2,2'd1,1'b0,1'b0,32'h0982A22E,32'h2E0982A2,4'h0,4'd5}, // R5
        {1'b0,2'd2,2'd2,1'b0,1'b0,32'h0982A22E,32'hA22E0982,4'h0,4'd5}, // R5
        {1'b0,2'd2,2'd3,1'b0,1'b0,32'h0982A22E,32'h82A22E09,4'h0,4'd5}, // R5
        {1'b0,2'd2,2'd0,1'b0,1'b1,32'h0982A22E,32'h0982A22E,4'h0,4'd6}, // R6
        {1'b0,2'd2,2'd1,1'b0,1'b1,32'h0982A22E,32'h82A22E09,4'h0,4'd6}, // R6
        {1'b0,2'd2,2'd2,1'b0,1'b1,32'h0982A22E,32'hA22E0982,4'h0,4'd6}, // R6
        {1'b0,2'd2,2'd3,1'b0,1'b1,32'h0982A22E,32'h2E0982A2,4'h0,4'd6}, // R6
        {1'b0,2'd2,2'd0,1'b1,1'b0,32'h80000000,32'h80000000,4'h0,4'd10}, // R10
        {1'b0,2'd3,2'd1,1'b0,1'b0,32'h0982A22E,32'h2E0982A2,4'h0,4'd10}, // R10
        {1'b0,2'd3,2'd1,1'b1,1'b1,32'h0982A22E,32'h82A22E09,4'h0,4'd10}, // R10
        {1'b1,2'd0,2'd0,1'b0,1'b0,32'hA1B2C3D4,32'hD4D4D4D4,4'h1,4'd8}, // R8
        {1'b1,2'd0,2'd1,1'b0,1'b0,32'hA1B2C3D4,32'hD4D4D4D4,4'h2,4'd8}, // R8
        {1'b1,2'd0,2'd2,1'b0,1'b0,32'hA1B2C3D4,32'hD4D4D4D4,4'h4,4'd8}, // R8
        {1'b1,2'd0,2'd3,1'b0,1'b0,32'hA1B2C3D4,32'hD4D4D4D4,4'h8,4'd8}, // R8
        {1'b1,2'd0,2'd0,1'b0,1'b1,32'hA1B2C3D4,32'hD4D4D4D4,4'h8,4'd8}, // R8 R7
        {1'b1,2'd0,2'd3,1'b0,1'b1,32'hA1B2C3D4,32'hD4D4D4D4,4'h1,4'd8}, // R8 R7
        {1'b1,2'd1,2'd0,1'b0,1'b0,32'hA1B2C3D4,32'hC3D4C3D4,4'h3,4'd9}, // R9
        {1'b1,2'd1,2'd1,1'b0,1'b0,32'hA1B2C3D4,32'hC3D4C3D4,4'h3,4'd9}, // R9
        {1'b1,2'd1,2'd2,1'b0,1'b0,32'hA1B2C3D4,32'hC3D4C3D4,4'hC,4'd9}, // R9
        {1'b1,2'd1,2'd0,1'b0,1'b1,32'hA1B2C3D4,32'hC3D4C3D4,4'hC,4'd9}, // R9
        {1'b1,2'd1,2'd3,1'b0,1'b1,32'hA1B2C3D4,32'hC3D4C3D4,4'h3,4'd9}, // R9
        {1'b1,2'd2,2'd3,1'b0,1'b0,32'hA1B2C3D4,32'hA1B2C3D4,4'hF,4'd10}, // R10
        {1'b1,2'd3,2'd2,1'b1,1'b1,32'hA1B2C3D4,32'hA1B2C3D4,4'hF,4'd10}  // R10
    };

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Apply inputs at a rising edge; results are sampled at the following falling edge.
    task automatic apply(input logic st, input logic [1:0] sz, input logic [1:0] ofs,
                         input logic sx, input logic be, input logic [31:0] din);
        @(posedge clk);
        acc_size   = sz;
        addr_lo    = ofs;
        sign_ext   = sx;
        big_endian = be;
        ld_word    = st ? 32'h0 : din;
        st_reg     = st ? din : 32'h0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // Reset state: zero inputs give zero data and a lane-0 byte enable (R1, R8).
        @(negedge clk);
        check32("R1 reset ld_result", ld_result, 32'h0);
        check32("R8 reset st_byte_en", {28'h0, st_byte_en}, 32'h1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [78:0] v;
            string tag;
            v = VEC[i];
            apply(v[78], v[77:76], v[75:74], v[73], v[72], v[71:40]);
            tag = $sformatf("R%0d vec%0d", v[3:0], i);
            if (v[78]) begin
                check32({tag, " st_data"}, st_data, v[39:8]);
                check32({tag, " st_byte_en"}, {28'h0, st_byte_en}, {28'h0, v[7:4]});
            end else begin
                check32({tag, " ld_result"}, ld_result, v[39:8]);
            end
        end

        // R7 R10: big-endian word store, then a byte load of that data at offset 0 gives the MSB.
        apply(1'b1, 2'd2, 2'd0, 1'b0, 1'b1, 32'h11223344);
        check32("R10 be store data", st_data, 32'h11223344);
        apply(1'b0, 2'd0, 2'd0, 1'b0, 1'b1, st_data);
        check32("R7 be roundtrip byte", ld_result, 32'h00000011);
        apply(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 32'h11223344);
        check32("R7 le byte at base", ld_result, 32'h00000044);

        // R9: offset bit 0 has no effect; same data and enables for offsets 2 and 3.
        apply(1'b1, 2'd1, 2'd3, 1'b0, 1'b0, 32'h0000BEEF);
        check32("R9 odd half data", st_data, 32'hBEEFBEEF);
        check32("R9 odd half en", {28'h0, st_byte_en}, 32'hC);

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule